// File: doc/BRIEF.md
# Internal-XOR Pattern Generator with Serial Seeding

This block is a linear feedback shift register of degree N in the division (internal-XOR) form, meant as the stimulus source of a built-in self-test path. It has N flip-flops, labelled O1 (lowest stage) up to ON (highest stage). The bit leaving ON is the feedback bit. On every step it is XORed into each stage whose polynomial coefficient is 1, and it enters O1 together with the serial input. The x^N and x^0 terms are always present. The middle coefficients x^1 to x^(N-1) come from a tap input, which is captured only when the register is cleared.

A run always starts with a clear, which zeroes the whole register. The seed is then shifted in one bit per clock through the serial input. Because the serial input is mixed into the feedback path, the seed is divided through the polynomial rather than copied in. In generate mode the serial input is forced to 0 and the register steps on its own.

The full state is presented in parallel each cycle, and a valid flag marks the cycles in which that state came from a generate step.

Top module: `div_lfsr_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, state_o is all zeros and pattern_valid_o is 0.
- R2: Mode code 2'b01 (clear) sets state_o to all zeros on the next clock edge, whatever the previous state was.
- R3: Mode code 2'b00 (hold) leaves state_o unchanged across the clock edge, whatever serial_i carries.
- R4: Mode code 2'b10 (seed-shift) computes each bit of the new state as follows. New bit 0 is old bit N-1 XOR serial_i. New bit k, for k from 1 to N-1, is old bit k-1 XOR (old bit N-1 AND taps_q bit k-1).
- R5: Mode code 2'b11 (generate) applies the same update as R4 with serial_i treated as 0. A 1 on serial_i in generate mode has no effect on state_o.
- R6: On a clear, taps_i is captured. Bit j of taps_i is the coefficient of x^(j+1). A change on taps_i in any other mode has no effect on later steps.
- R7: pattern_valid_o is 1 in the cycle after a clock edge that saw mode 2'b11, and 0 after any other mode.
- R8: With N=3 and a primitive polynomial (x^3+x^2+1, taps 2'b10; or x^3+x+1, taps 2'b01), generate mode seeded with 001 passes through all 7 nonzero states and returns to 001 after exactly 7 steps.
- R9: An all-zero state stays all-zero under generate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 hold, 01 clear, 10 seed-shift, 11 generate |
| serial_i | input | 1 | Serial seed bit, used only in seed-shift |
| taps_i | input | N-1 | Coefficients of x^1..x^(N-1); bit j is x^(j+1); sampled on clear |
| state_o | output | N | Parallel register state; bit k is stage O(k+1) |
| pattern_valid_o | output | 1 | State was produced by a generate step |

## Verification
The hardest condition to reach from the ports is a change of taps_i that must not matter. The bench changes the polynomial on taps_i during generate and hold steps and never issues a clear. It then checks, for many steps, that every new state still follows the polynomial captured at the last clear. The full-period property is reached by clearing a 3-stage instance, shifting in a single 1, and running exactly seven generate steps while the bench records every state it sees.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_SEED  = 2'b10,
    MODE_GEN   = 2'b11
  } lfsr_mode_e;

  typedef struct packed {
    logic clr;
    logic step;
    logic use_serial;
    logic gen;
  } lfsr_ctrl_t;

endpackage

// File: rtl/lfsr_mode_decode.sv
module lfsr_mode_decode
  import lfsr_pkg::*;
(
  input  logic [1:0] mode_i,
  output lfsr_ctrl_t ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (lfsr_mode_e'(mode_i))
      MODE_CLEAR: ctrl_o.clr = 1'b1;
      MODE_SEED: begin
        ctrl_o.step       = 1'b1;
        ctrl_o.use_serial = 1'b1;
      end
      MODE_GEN: begin
        ctrl_o.step = 1'b1;
        ctrl_o.gen  = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/lfsr_tap_reg.sv
module lfsr_tap_reg #(
  parameter int unsigned N = 8,
  parameter logic [N-2:0] RESET_TAPS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture_i,
  input  logic [N-2:0] taps_i,
  output logic [N-2:0] taps_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         taps_q <= RESET_TAPS;
    else if (capture_i) taps_q <= taps_i;
  end

endmodule

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         din_i,
  input  logic [N-2:0] taps_i,
  output logic [N-1:0] state_o,
  output logic         feedback_o
);

  logic [N-1:0] stage_q;
  logic [N-1:0] stage_d;
  logic         fb;

  assign fb = stage_q[N-1];

  for (genvar g = 0; g < N; g++) begin : g_stage
    if (g == 0) begin : g_low
      assign stage_d[g] = fb ^ din_i;
    end else begin : g_mid
      assign stage_d[g] = stage_q[g-1] ^ (taps_i[g-1] & fb);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stage_q <= '0;
    else if (clr_i)  stage_q <= '0;
    else if (step_i) stage_q <= stage_d;
  end

  assign state_o    = stage_q;
  assign feedback_o = fb;

endmodule

// File: rtl/div_lfsr_gen.sv
module div_lfsr_gen
  import lfsr_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter logic [N-2:0] RESET_TAPS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_i,
  input  logic         serial_i,
  input  logic [N-2:0] taps_i,
  output logic [N-1:0] state_o,
  output logic         pattern_valid_o
);

  lfsr_ctrl_t   ctrl;
  logic [N-2:0] taps_q;
  logic         din_eff;
  logic         feedback;
  logic         valid_q;

  lfsr_mode_decode u_dec (
    .mode_i (mode_i),
    .ctrl_o (ctrl)
  );

  lfsr_tap_reg #(.N(N), .RESET_TAPS(RESET_TAPS)) u_taps (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (ctrl.clr),
    .taps_i    (taps_i),
    .taps_q    (taps_q)
  );

  assign din_eff = ctrl.use_serial & serial_i;

  lfsr_core #(.N(N)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (ctrl.clr),
    .step_i     (ctrl.step),
    .din_i      (din_eff),
    .taps_i     (taps_q),
    .state_o    (state_o),
    .feedback_o (feedback)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= ctrl.gen;
  end

  assign pattern_valid_o = valid_q;

  logic unused_fb;
  assign unused_fb = feedback;

endmodule

// File: rtl/lfsr_chk.sv
module lfsr_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_i,
  input logic         serial_i,
  input logic [N-1:0] state_o,
  input logic         pattern_valid_o,
  input logic [N-2:0] taps_q
);

  // R2
  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b01 |=> state_o == '0);

  // R3
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b00 |=> $stable(state_o));

  // R4: no feedback, plain shift with serial bit entering O1
  a_r4_seed_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && !state_o[N-1]) |=>
      state_o == {$past(state_o[N-2:0]), $past(serial_i)});

  // R5: no feedback, serial input ignored
  a_r5_gen_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && !state_o[N-1]) |=>
      state_o == {$past(state_o[N-2:0]), 1'b0});

  // R6
  a_r6_taps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i != 2'b01 |=> $stable(taps_q));

  // R7
  a_r7_valid_after_gen: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b11 |=> pattern_valid_o);

  a_r7_invalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i != 2'b11 |=> !pattern_valid_o);

  // R9
  a_r9_zero_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && state_o == '0) |=> state_o == '0);

endmodule

bind div_lfsr_gen lfsr_chk #(.N(N)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode_i          (mode_i),
  .serial_i        (serial_i),
  .state_o         (state_o),
  .pattern_valid_o (pattern_valid_o),
  .taps_q          (taps_q)
);

// File: tb/div_lfsr_gen_tb.sv
`timescale 1ns/1ps
module div_lfsr_gen_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] mode8 = 2'b00;
  logic       ser8 = 1'b0;
  logic [6:0] taps8 = '0;
  logic [7:0] st8;
  logic       v8;

  logic [1:0] mode3 = 2'b00;
  logic       ser3 = 1'b0;
  logic [1:0] taps3 = '0;
  logic [2:0] st3;
  logic       v3;

  div_lfsr_gen #(.N(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode8), .serial_i(ser8),
    .taps_i(taps8), .state_o(st8), .pattern_valid_o(v8));

  div_lfsr_gen #(.N(3)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode3), .serial_i(ser3),
    .taps_i(taps3), .state_o(st3), .pattern_valid_o(v3));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference: polynomial division on integers
  int m8_state = 0, m8_poly = 9'h101;
  int m3_state = 0, m3_poly = 4'h9;

  function automatic int ref_next(int s, int poly, int deg, int bitin);
    int v;
    v = (s * 2) + bitin;
    if (v >= (1 << deg)) v = v ^ poly;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step8(logic [1:0] m, logic s, logic [6:0] t, string req);
    int expv;
    @(negedge clk);
    mode8 = m; ser8 = s; taps8 = t;
    @(posedge clk); #1;
    case (m)
      2'b01: begin m8_state = 0; m8_poly = 256 + (int'(t) * 2) + 1; end
      2'b10: m8_state = ref_next(m8_state, m8_poly, 8, int'(s));
      2'b11: m8_state = ref_next(m8_state, m8_poly, 8, 0);
      default: ;
    endcase
    expv = (m == 2'b11) ? 1 : 0;
    check(req, int'(st8), m8_state);
    check("R7", int'(v8), expv);
  endtask

  task automatic step3(logic [1:0] m, logic s, logic [1:0] t, string req);
    @(negedge clk);
    mode3 = m; ser3 = s; taps3 = t;
    @(posedge clk); #1;
    case (m)
      2'b01: begin m3_state = 0; m3_poly = 8 + (int'(t) * 2) + 1; end
      2'b10: m3_state = ref_next(m3_state, m3_poly, 3, int'(s));
      2'b11: m3_state = ref_next(m3_state, m3_poly, 3, 0);
      default: ;
    endcase
    check(req, int'(st3), m3_state);
  endtask

  task automatic seed8(logic [7:0] sd, logic [6:0] t);
    for (int i = 7; i >= 0; i--) step8(2'b10, sd[i], t, "R4");
  endtask

  task automatic period3(logic [1:0] t);
    bit seen [8];
    for (int i = 0; i < 8; i++) seen[i] = 0;
    step3(2'b01, 1'b0, t, "R2");
    step3(2'b10, 1'b1, t, "R4");
    check("R8", int'(st3), 1);
    for (int i = 0; i < 7; i++) begin
      step3(2'b11, 1'b0, t, "R8");
      check("R8", int'(st3 != 3'b000), 1);
      check("R8", int'(seen[st3]), 0);
      seen[st3] = 1;
    end
    check("R8", int'(st3), 1);
  endtask

  initial begin
    #1;
    check("R1", int'(st8), 0);
    check("R1", int'(v8), 0);
    #9;
    check("R1", int'(st8), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(st8), 0);
    check("R1", int'(v8), 0);

    // x^8+x^6+x^3+x^2+1
    step8(2'b01, 1'b0, 7'b0100110, "R2");
    seed8(8'b10001101, 7'b0100110);
    for (int i = 0; i < 42; i++) step8(2'b11, 1'b0, 7'b0100110, "R5");
    for (int i = 0; i < 4; i++) step8(2'b00, i[0], 7'b0100110, "R3");
    for (int i = 0; i < 10; i++) step8(2'b11, 1'b1, 7'b0100110, "R5");
    // taps input changes without a clear: must be ignored
    for (int i = 0; i < 20; i++) step8(2'b11, 1'b0, 7'b1111111, "R6");
    for (int i = 0; i < 3; i++) step8(2'b00, 1'b1, 7'b0000001, "R6");
    for (int i = 0; i < 10; i++) step8(2'b11, 1'b0, 7'b1010101, "R6");
    // clear from nonzero state, new polynomial x^8+x^5+x^4+x+1
    step8(2'b01, 1'b1, 7'b0011001, "R2");
    seed8(8'b01010111, 7'b1111111);
    for (int i = 0; i < 30; i++) step8(2'b11, 1'b0, 7'b0000000, "R5");
    // reseed in the middle of a run
    seed8(8'b11110000, 7'b0000000);
    for (int i = 0; i < 12; i++) step8(2'b11, 1'b0, 7'b0000000, "R4");
    // zero lock
    step8(2'b01, 1'b0, 7'b0100110, "R2");
    for (int i = 0; i < 6; i++) step8(2'b11, 1'b1, 7'b0100110, "R9");

    period3(2'b10);
    period3(2'b01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule